// File: doc/BRIEF.md
# Interlocked Four-Phase Read Bus

This block joins a bus master and a memory slave that run on unrelated clocks. Neither side relies on the other's clock. Every step of a read waits for the other side to answer on a control line, so a fast master and a slow slave can share the wires safely.

The master side takes a read command with an address. It puts the address on the address wires and raises Request, then waits. The slave latches the address and answers on the shared Ack line. After a programmable number of its own cycles, it drives the data wires and raises DataReady. The master captures the word and raises its own acknowledgement on the same Ack line. The slave then takes its data off the bus. Once every control line has returned low, the master reports the word with a one-cycle done pulse.

Each side sees the other's control lines only through two flip-flop synchronisers in its own clock domain. The bus model has no tristates. Each wire group is gated by the enable of its one owner, and the shared Ack line is the OR of the two acknowledgement drivers.

Master states and transitions:
- `M_IDLE` goes to `M_REQ` when a command is accepted.
- `M_REQ` goes to `M_WAIT_DATA` when Ack is seen.
- `M_WAIT_DATA` goes to `M_ACK` when DataReady is seen, capturing the word.
- `M_ACK` goes to `M_SETTLE` when DataReady drops.
- `M_SETTLE` goes to `M_DONE` when Ack and DataReady are both seen low.
- `M_DONE` goes to `M_IDLE`.

Slave states and transitions:
- `S_IDLE` goes to `S_HOLD` when Request is seen, latching the address.
- `S_HOLD` goes to `S_RELEASE` when Request drops.
- `S_RELEASE` goes to `S_DELAY` when the Ack line is seen low, loading the latency count.
- `S_DELAY` goes to `S_DRIVE` when the count is zero.
- `S_DRIVE` goes to `S_IDLE` when the master's Ack is seen.

Top module: `hs_read_bus`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0, and `bus_req`, `bus_ack`, `bus_drdy`, `bus_addr_oe` and `bus_data_oe` are all 0.
- R2: A command is accepted on a master clock edge where `cmd_ready` and `cmd_valid` are both 1. `bus_req` and `bus_addr_oe` then rise together, with `bus_addr` equal to the command address. The slave raises Ack only after it has seen Request.
- R3: The master keeps `bus_addr_oe` and `bus_req` high until it has seen Ack. So when `bus_addr_oe` falls, `bus_ack` is high.
- R4: While `bus_drdy` is 1, `bus_data_oe` is 1 and `bus_data` holds the addressed word without change.
- R5: The master raises its acknowledgement only after seeing DataReady. The slave drops `bus_drdy` and `bus_data_oe` only after seeing Ack, so when `bus_drdy` falls, `bus_ack` is still high.
- R6: With `lat_cfg` = L (0 to 15), `bus_drdy` rises exactly 4+L slave clock edges after the slave drops Ack. This is 3 edges for the synchroniser to confirm the line is low, 1 edge to load the count, and L counting edges.
- R7: Each accepted command gives exactly one `done` pulse, one master cycle long. It arrives only once `bus_req`, `bus_ack` and `bus_drdy` are all low again, and results come back in command order.
- R8: `cmd_valid` is ignored while `cmd_ready` is 0. No extra Request is issued, and the pending read's address and result are unchanged.
- R9: The slave memory word at address a equals SEED ^ (a * STEP), truncated to DW bits. With the defaults this is 16'h5A3C ^ (a * 16'h0107). `done_data` carries that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_m_n | input | 1 | Master reset, active low |
| clk_s | input | 1 | Slave clock |
| rst_s_n | input | 1 | Slave reset, active low |
| cmd_valid | input | 1 | Read command present |
| cmd_addr | input | AW | Read address |
| cmd_ready | output | 1 | Master idle, command can be taken |
| done | output | 1 | One-cycle pulse, read finished |
| done_data | output | DW | Word returned by the read |
| lat_cfg | input | LW | Slave response latency in slave cycles |
| bus_req | output | 1 | Request line (master) |
| bus_ack | output | 1 | Shared Ack line (OR of both sides) |
| bus_drdy | output | 1 | DataReady line (slave) |
| bus_addr_oe | output | 1 | Master drives address wires |
| bus_data_oe | output | 1 | Slave drives data wires |
| bus_addr | output | AW | Address wires |
| bus_data | output | DW | Data wires |

## Verification
The overall time to `done` depends on the phase between the two clocks, so the bench does not predict the done cycle. A driver records each address in a scoreboard, and a monitor on the master's falling edge pairs every done pulse with the oldest entry.

The four hand-off steps are checked on the same falling edge, at the cycle where a control line changes. The address is checked where Request rises, Ack where the address enable falls, the data on every DataReady cycle, and Ack again where DataReady falls.

The only exactly timed result is the slave's response delay. It is counted on slave falling edges from the Ack fall to the DataReady rise, and must equal 4+L.

// File: rtl/hs_read_pkg.sv
`timescale 1ns/100ps
package hs_read_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_REQ,
        M_WAIT_DATA,
        M_ACK,
        M_SETTLE,
        M_DONE
    } mst_state_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD,
        S_RELEASE,
        S_DELAY,
        S_DRIVE
    } slv_state_e;

endpackage

// File: rtl/hs_sync2.sv
`timescale 1ns/100ps
// Two-stage synchroniser, one pair of flops per bit.
module hs_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= d[i];
                stage2 <= stage1;
            end
        end
        assign q[i] = stage2;
    end

endmodule

// File: rtl/hs_rd_master.sv
`timescale 1ns/100ps
module hs_rd_master
    import hs_read_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    output logic          cmd_ready,
    output logic          done,
    output logic [DW-1:0] done_data,
    output logic          req_o,
    output logic          addr_oe_o,
    output logic [AW-1:0] addr_o,
    output logic          mack_o,
    input  logic          ack_line,
    input  logic          drdy_line,
    input  logic [DW-1:0] data_line
);

    mst_state_e    state_q, state_d;
    logic          ack_s, drdy_s;
    logic [1:0]    sync_q;
    logic          req_q, addr_oe_q, mack_q, done_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    hs_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ack_line, drdy_line}),
        .q     (sync_q)
    );
    assign ack_s  = sync_q[1];
    assign drdy_s = sync_q[0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE:      if (cmd_valid)          state_d = M_REQ;
            M_REQ:       if (ack_s)              state_d = M_WAIT_DATA;
            M_WAIT_DATA: if (drdy_s)             state_d = M_ACK;
            M_ACK:       if (!drdy_s)            state_d = M_SETTLE;
            M_SETTLE:    if (!ack_s && !drdy_s)  state_d = M_DONE;
            M_DONE:                              state_d = M_IDLE;
            default:                             state_d = M_IDLE;
        endcase
    end

    // Registered outputs decoded from the next state: glitch-free lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            addr_oe_q <= 1'b0;
            mack_q    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            req_q     <= (state_d == M_REQ);
            addr_oe_q <= (state_d == M_REQ);
            mack_q    <= (state_d == M_ACK);
            done_q    <= (state_d == M_DONE);
        end
    end

    // Command address and captured word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (state_q == M_IDLE && cmd_valid)  addr_q <= cmd_addr;
            if (state_q == M_WAIT_DATA && drdy_s) data_q <= data_line;
        end
    end

    assign cmd_ready = (state_q == M_IDLE);
    assign done      = done_q;
    assign done_data = data_q;
    assign req_o     = req_q;
    assign addr_oe_o = addr_oe_q;
    assign addr_o    = addr_q;
    assign mack_o    = mack_q;

    // Address wires are released only after Ack was observed
    p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_oe_q) |-> $past(ack_s));

    // Master acknowledgement follows an observed DataReady
    p_mack_after_drdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mack_q) |-> $past(drdy_s));

    // Done only once every control line is back low
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!ack_s && !drdy_s && !req_q));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // A busy master keeps its pending address
    p_busy_keeps_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != M_IDLE) |=> $stable(addr_q));

endmodule

// File: rtl/hs_rd_slave.sv
`timescale 1ns/100ps
module hs_rd_slave
    import hs_read_pkg::*;
#(
    parameter int          AW   = 4,
    parameter int          DW   = 16,
    parameter int          LW   = 4,
    parameter logic [DW-1:0] SEED = 16'h5A3C,
    parameter logic [DW-1:0] STEP = 16'h0107
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lat_cfg,
    input  logic          req_line,
    input  logic          ack_line,
    input  logic [AW-1:0] addr_line,
    output logic          sack_o,
    output logic          drdy_o,
    output logic          data_oe_o,
    output logic [DW-1:0] data_o
);

    localparam int DEPTH = 1 << AW;

    slv_state_e    state_q, state_d;
    logic          req_s, ack_s;
    logic [1:0]    sync_q;
    logic [LW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic          sack_q, drdy_q, data_oe_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rom [DEPTH];

    // Local memory contents, computed per word
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign rom[g] = SEED ^ (DW'(g) * STEP);
    end

    hs_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({req_line, ack_line}),
        .q     (sync_q)
    );
    assign req_s = sync_q[1];
    assign ack_s = sync_q[0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_s)          state_d = S_HOLD;
            S_HOLD:    if (!req_s)         state_d = S_RELEASE;
            S_RELEASE: if (!ack_s)         state_d = S_DELAY;
            S_DELAY:   if (cnt_q == '0)    state_d = S_DRIVE;
            S_DRIVE:   if (ack_s)          state_d = S_IDLE;
            default:                       state_d = S_IDLE;
        endcase
    end

    // Address latch and latency counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (state_q == S_IDLE && req_s) addr_q <= addr_line;
            if (state_q == S_RELEASE && !ack_s)
                cnt_q <= lat_cfg;
            else if (state_q == S_DELAY && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sack_q    <= 1'b0;
            drdy_q    <= 1'b0;
            data_oe_q <= 1'b0;
            data_q    <= '0;
        end else begin
            sack_q    <= (state_d == S_HOLD);
            drdy_q    <= (state_d == S_DRIVE);
            data_oe_q <= (state_d == S_DRIVE);
            if (state_d == S_DRIVE && state_q != S_DRIVE)
                data_q <= rom[addr_q];
        end
    end

    assign sack_o    = sack_q;
    assign drdy_o    = drdy_q;
    assign data_oe_o = data_oe_q;
    assign data_o    = data_q;

    // Ack is raised only in answer to an observed Request
    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sack_q) |-> $past(req_s));

    // Data wires stay driven and steady while DataReady holds
    p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_q && $past(drdy_q)) |-> ($stable(data_q) && data_oe_q));

    // Data is withdrawn only after the master's Ack was observed
    p_drop_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_q) |-> $past(ack_s));

    // DataReady follows an exhausted latency count
    p_lat_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy_q) |-> $past(cnt_q == '0));

endmodule

// File: rtl/hs_read_bus.sv
`timescale 1ns/100ps
module hs_read_bus #(
    parameter int            AW   = 4,
    parameter int            DW   = 16,
    parameter int            LW   = 4,
    parameter logic [DW-1:0] SEED = 16'h5A3C,
    parameter logic [DW-1:0] STEP = 16'h0107
) (
    input  logic          clk_m,
    input  logic          rst_m_n,
    input  logic          clk_s,
    input  logic          rst_s_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    output logic          cmd_ready,
    output logic          done,
    output logic [DW-1:0] done_data,
    input  logic [LW-1:0] lat_cfg,
    output logic          bus_req,
    output logic          bus_ack,
    output logic          bus_drdy,
    output logic          bus_addr_oe,
    output logic          bus_data_oe,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data
);

    logic          m_req, m_addr_oe, m_ack;
    logic [AW-1:0] m_addr;
    logic          s_ack, s_drdy, s_data_oe;
    logic [DW-1:0] s_data;

    // Tristate-free wires: each group gated by its owner's enable
    assign bus_req     = m_req;
    assign bus_ack     = m_ack | s_ack;
    assign bus_drdy    = s_drdy;
    assign bus_addr_oe = m_addr_oe;
    assign bus_data_oe = s_data_oe;
    assign bus_addr    = m_addr_oe ? m_addr : '0;
    assign bus_data    = s_data_oe ? s_data : '0;

    hs_rd_master #(.AW(AW), .DW(DW)) u_master (
        .clk       (clk_m),
        .rst_n     (rst_m_n),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_ready (cmd_ready),
        .done      (done),
        .done_data (done_data),
        .req_o     (m_req),
        .addr_oe_o (m_addr_oe),
        .addr_o    (m_addr),
        .mack_o    (m_ack),
        .ack_line  (bus_ack),
        .drdy_line (bus_drdy),
        .data_line (bus_data)
    );

    hs_rd_slave #(.AW(AW), .DW(DW), .LW(LW), .SEED(SEED), .STEP(STEP)) u_slave (
        .clk       (clk_s),
        .rst_n     (rst_s_n),
        .lat_cfg   (lat_cfg),
        .req_line  (bus_req),
        .ack_line  (bus_ack),
        .addr_line (bus_addr),
        .sack_o    (s_ack),
        .drdy_o    (s_drdy),
        .data_oe_o (s_data_oe),
        .data_o    (s_data)
    );

endmodule

// File: tb/tb_hs_read_bus.sv
`timescale 1ns/100ps
module tb_hs_read_bus;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int LW = 4;
    localparam int WATCHDOG = 60000;

    logic          clk_m = 1'b0, clk_s = 1'b0;
    logic          rst_m_n = 1'b0, rst_s_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] lat_cfg = '0;
    logic          cmd_ready, done;
    logic [DW-1:0] done_data;
    logic          bus_req, bus_ack, bus_drdy, bus_addr_oe, bus_data_oe;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;

    always #2.5 clk_m = ~clk_m;   // 200 MHz master clock
    always #3.3 clk_s = ~clk_s;   // unrelated slower slave clock

    hs_read_bus dut (
        .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
        .done(done), .done_data(done_data), .lat_cfg(lat_cfg),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_drdy(bus_drdy),
        .bus_addr_oe(bus_addr_oe), .bus_data_oe(bus_data_oe),
        .bus_addr(bus_addr), .bus_data(bus_data)
    );

    function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
        return 16'h5A3C ^ (16'(a) * 16'h0107);
    endfunction

    // Scoreboard FIFO: driver owns the write side, monitor the read side
    logic [AW-1:0] sb_addr [0:255];
    logic [LW-1:0] sb_lat  [0:255];
    int wr_idx = 0;
    int rd_idx = 0;

    int checks_main = 0, fails_main = 0;
    int checks_mon  = 0, fails_mon  = 0;
    int req_rises = 0;
    int meas_count = 0, meas_last = 0;

    task automatic chk_main(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks_main++;
        if (!ok) begin
            fails_main++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic chk_mon(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks_mon++;
        if (!ok) begin
            fails_mon++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Slave-side measurement of the response delay (R6)
    logic s_pack = 1'b0, s_pdrdy = 1'b0;
    int   s_cnt = 0;
    always @(negedge clk_s) begin
        if (rst_s_n) begin
            if (s_pack && !bus_ack) s_cnt = 0;
            else                    s_cnt = s_cnt + 1;
            if (bus_drdy && !s_pdrdy) begin
                meas_last  = s_cnt;
                meas_count = meas_count + 1;
            end
            s_pack  = bus_ack;
            s_pdrdy = bus_drdy;
        end
    end

    // Master-side monitor: hand-off steps and scoreboard compare
    logic p_req = 1'b0, p_aoe = 1'b0, p_drdy = 1'b0, p_done = 1'b0;
    int   done_seen = 0;
    always @(negedge clk_m) begin
        if (rst_m_n) begin
            if (bus_req && !p_req) begin
                req_rises++;
                // R2: Request and address appear together
                chk_mon(bus_addr_oe && wr_idx > rd_idx && bus_addr == sb_addr[wr_idx-1],
                        "R2 addr on request", 32'(bus_addr), 32'(sb_addr[(wr_idx > 0) ? wr_idx-1 : 0]));
            end
            if (!bus_addr_oe && p_aoe)
                chk_mon(bus_ack, "R3 ack at address release", 32'(bus_ack), 32'd1);
            if (bus_drdy)
                chk_mon(bus_data_oe && bus_data == exp_word(sb_addr[rd_idx]),
                        "R4 data while ready", 32'(bus_data), 32'(exp_word(sb_addr[rd_idx])));
            if (!bus_drdy && p_drdy)
                chk_mon(bus_ack, "R5 ack at data release", 32'(bus_ack), 32'd1);
            if (done && p_done)
                chk_mon(1'b0, "R7 done wider than one cycle", 32'd2, 32'd1);
            if (done) begin
                done_seen++;
                if (rd_idx >= wr_idx) begin
                    chk_mon(1'b0, "R7 unexpected done", 32'(done_data), 32'd0);
                end else begin
                    chk_mon(done_data == exp_word(sb_addr[rd_idx]), "R9 returned word",
                            32'(done_data), 32'(exp_word(sb_addr[rd_idx])));
                    chk_mon(!bus_req && !bus_ack && !bus_drdy, "R7 lines idle at done",
                            {29'd0, bus_req, bus_ack, bus_drdy}, 32'd0);
                    chk_mon(meas_count == done_seen && meas_last == 4 + int'(sb_lat[rd_idx]),
                            "R6 slave response delay", 32'(meas_last), 32'(4 + int'(sb_lat[rd_idx])));
                    rd_idx++;
                end
            end
            p_req  = bus_req;
            p_aoe  = bus_addr_oe;
            p_drdy = bus_drdy;
            p_done = done;
        end
    end

    task automatic wait_idle();
        @(negedge clk_m);
        while (!(cmd_ready && rd_idx == wr_idx)) @(negedge clk_m);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [LW-1:0] l, input bit spam);
        wait_idle();
        lat_cfg  = l;
        sb_addr[wr_idx] = a;
        sb_lat[wr_idx]  = l;
        wr_idx++;
        cmd_addr  = a;
        cmd_valid = 1'b1;
        @(negedge clk_m);
        cmd_valid = 1'b0;
        if (spam) begin
            // R8: commands offered while busy must be ignored
            cmd_addr  = ~a;
            cmd_valid = 1'b1;
            while (!cmd_ready) @(negedge clk_m);
            cmd_valid = 1'b0;
        end
    endtask

    task automatic run_all();
        repeat (4) @(negedge clk_m);
        rst_m_n = 1'b1;
        rst_s_n = 1'b1;
        @(negedge clk_m);
        // R1: reset state
        chk_main(cmd_ready && !done, "R1 ready/done after reset", {30'd0, cmd_ready, done}, 32'd2);
        chk_main(!bus_req && !bus_ack && !bus_drdy && !bus_addr_oe && !bus_data_oe,
                 "R1 bus lines after reset",
                 {27'd0, bus_req, bus_ack, bus_drdy, bus_addr_oe, bus_data_oe}, 32'd0);
        do_read(4'h0, 4'd0,  1'b0);
        do_read(4'hF, 4'd15, 1'b0);
        do_read(4'h5, 4'd7,  1'b1);
        do_read(4'hA, 4'd0,  1'b1);
        for (int a = 0; a < 16; a++)
            do_read(AW'(a), LW'((a * 5) % 16), 1'b0);
        wait_idle();
        chk_main(done_seen == wr_idx, "R7 one done per command", 32'(done_seen), 32'(wr_idx));
        chk_main(req_rises == wr_idx, "R8 one request per accepted command", 32'(req_rises), 32'(wr_idx));
    endtask

    initial begin
        bit wd_hit;
        wd_hit = 1'b0;
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk_m);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks_main++;
            fails_main++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", done_seen, wr_idx);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks_main + checks_mon, fails_main + fails_mon);
        $finish;
    end

endmodule